// File: doc/BRIEF.md
# Banked Window Address Decoder

This block sits in front of a secondary processor with a 16-bit address space. It sorts each access into one of three regions. The low quarter goes to a small local RAM. The upper half becomes a movable 32 KB window onto a 24-bit main bus. The quarter between them is left for other hardware, and this block selects nothing there. The window base sits in a 9-bit bank register. Software loads it one bit at a time: each bank write shifts the register toward its low end and puts the new bit at its top.

All outputs are registered. An access presented with the strobe is decoded at a clock edge, and the selects and addresses show it for one cycle after that edge. The decode uses the bank value held just before the edge. A bank write in the same cycle therefore affects only later accesses.

Top module: `bank_window_decoder`

## Requirements
- R1: After reset, the bank register reads 0 and both selects and both address outputs are 0.
- R2: Each cycle with `bank_wr` high loads the bank register with `{bank_bit, old[8:1]}`: the new bit enters bank bit 8 (main-bus bit 23) and the old bit 0 is lost.
- R3: In a cycle without `bank_wr`, the bank register on `bank_base` keeps its value.
- R4: A strobed access with address bits 15:14 = 00 raises `ram_sel`, with `ram_addr` = address bits 12:0. So 0x0000, 0x2000 and their offsets reach the same RAM byte.
- R5: A strobed access with address bit 15 = 1 raises `win_sel`, with `win_addr` = {bank register, address bits 14:0}. This is a 32 KB window aligned to 0x8000.
- R6: A strobed access with address bits 15:14 = 01 raises neither select, and both address outputs are 0.
- R7: A cycle without `acc_strobe` raises neither select, and both address outputs are 0.
- R8: Each decode appears on the outputs one cycle after the edge that samples it. A bank write in the same cycle does not change that decode's window address.
- R9: Nine consecutive bank writes replace the whole base. The first bit written ends in bank bit 0 (main-bus bit 15), and the last ends in bank bit 8.
- R10: `ram_sel` and `win_sel` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_strobe | input | 1 | Access valid this cycle (read or write) |
| acc_addr | input | 16 | Secondary-processor address |
| bank_wr | input | 1 | Bank register shift strobe |
| bank_bit | input | 1 | Bit shifted into the bank top |
| ram_sel | output | 1 | Local RAM selected |
| ram_addr | output | 13 | Local RAM byte address |
| win_sel | output | 1 | Main-bus window selected |
| win_addr | output | 24 | Main-bus byte address |
| bank_base | output | 9 | Bank register readback (main-bus bits 23:15) |

## Verification
Accesses are made at both ends of each region and on either side of the 0x4000 and 0x8000 boundaries. This separates the two-bit region test from a one-bit test. RAM accesses at 0x0000 and 0x3FFF against their 0x2000-mirror partners show that only bits 12:0 reach the RAM. Window accesses are repeated under bases made of alternating, single-one and all-ones bit patterns, and these expose a swapped shift direction or a misplaced base. A bank write issued in the same cycle as a window access shows which base value that access uses.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_RAM  = 2'd1,
    RGN_HW   = 2'd2,
    RGN_WIN  = 2'd3
  } region_t;
endpackage

// File: rtl/bwd_bank_shifter.sv
module bwd_bank_shifter #(
  parameter int BANK_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              shift_in,
  output logic [BANK_W-1:0] base
);
  // New bit lands at the top; older bits move toward bit 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      base <= '0;
    end else if (shift_en) begin
      base <= {shift_in, base[BANK_W-1:1]};
    end
  end
endmodule

// File: rtl/bwd_region_decode.sv
module bwd_region_decode
  import bwd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              strobe,
  input  logic [ADDR_W-1:0] addr,
  output region_t           region
);
  logic [1:0] top2;
  assign top2 = addr[ADDR_W-1 -: 2];

  always_comb begin
    if (!strobe) begin
      region = RGN_NONE;
    end else if (top2[1]) begin
      region = RGN_WIN;
    end else if (top2[0]) begin
      region = RGN_HW;
    end else begin
      region = RGN_RAM;
    end
  end
endmodule

// File: rtl/bwd_out_stage.sv
module bwd_out_stage
  import bwd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int RAM_AW = 13,
  parameter int WIN_AW = 15,
  parameter int MAIN_W = 24,
  localparam int BANK_W = MAIN_W - WIN_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  region_t           region,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] base,
  output logic              ram_sel,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              win_sel,
  output logic [MAIN_W-1:0] win_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_sel  <= 1'b0;
      ram_addr <= '0;
      win_sel  <= 1'b0;
      win_addr <= '0;
    end else begin
      ram_sel  <= (region == RGN_RAM);
      win_sel  <= (region == RGN_WIN);
      ram_addr <= (region == RGN_RAM) ? addr[RAM_AW-1:0] : '0;
      win_addr <= (region == RGN_WIN) ? {base, addr[WIN_AW-1:0]} : '0;
    end
  end
endmodule

// File: rtl/bank_window_decoder.sv
module bank_window_decoder
  import bwd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int RAM_AW = 13,
  parameter int WIN_AW = 15,
  parameter int MAIN_W = 24,
  localparam int BANK_W = MAIN_W - WIN_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_strobe,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              bank_wr,
  input  logic              bank_bit,
  output logic              ram_sel,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              win_sel,
  output logic [MAIN_W-1:0] win_addr,
  output logic [BANK_W-1:0] bank_base
);
  region_t rgn;

  bwd_bank_shifter #(.BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst(rst), .shift_en(bank_wr), .shift_in(bank_bit),
    .base(bank_base)
  );

  bwd_region_decode #(.ADDR_W(ADDR_W)) u_dec (
    .strobe(acc_strobe), .addr(acc_addr), .region(rgn)
  );

  bwd_out_stage #(
    .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .WIN_AW(WIN_AW), .MAIN_W(MAIN_W)
  ) u_out (
    .clk(clk), .rst(rst), .region(rgn), .addr(acc_addr), .base(bank_base),
    .ram_sel(ram_sel), .ram_addr(ram_addr),
    .win_sel(win_sel), .win_addr(win_addr)
  );
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker #(
  parameter int ADDR_W = 16,
  parameter int RAM_AW = 13,
  parameter int WIN_AW = 15,
  parameter int MAIN_W = 24,
  localparam int BANK_W = MAIN_W - WIN_AW
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_strobe,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              bank_wr,
  input logic              bank_bit,
  input logic              ram_sel,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              win_sel,
  input logic [MAIN_W-1:0] win_addr,
  input logic [BANK_W-1:0] bank_base
);
  a_r2_shift_in_top: assert property (@(posedge clk) disable iff (rst)
    bank_wr |=> bank_base == {$past(bank_bit), $past(bank_base[BANK_W-1:1])});

  a_r3_hold_base: assert property (@(posedge clk) disable iff (rst)
    !bank_wr |=> $stable(bank_base));

  a_r4_ram_map: assert property (@(posedge clk) disable iff (rst)
    (acc_strobe && acc_addr[ADDR_W-1 -: 2] == 2'b00)
      |=> ram_sel && !win_sel && ram_addr == $past(acc_addr[RAM_AW-1:0]));

  a_r5_win_map: assert property (@(posedge clk) disable iff (rst)
    (acc_strobe && acc_addr[ADDR_W-1])
      |=> win_sel && win_addr == {$past(bank_base), $past(acc_addr[WIN_AW-1:0])});

  a_r6_hw_hole: assert property (@(posedge clk) disable iff (rst)
    (acc_strobe && acc_addr[ADDR_W-1 -: 2] == 2'b01) |=> !ram_sel && !win_sel);

  a_r7_idle: assert property (@(posedge clk) disable iff (rst)
    !acc_strobe |=> !ram_sel && !win_sel);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ram_sel && win_sel));
endmodule

bind bank_window_decoder bwd_checker #(
  .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .WIN_AW(WIN_AW), .MAIN_W(MAIN_W)
) u_chk (
  .clk(clk), .rst(rst), .acc_strobe(acc_strobe), .acc_addr(acc_addr),
  .bank_wr(bank_wr), .bank_bit(bank_bit), .ram_sel(ram_sel),
  .ram_addr(ram_addr), .win_sel(win_sel), .win_addr(win_addr),
  .bank_base(bank_base)
);

// File: tb/bank_window_decoder_tb.sv
module bank_window_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_strobe = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        bank_wr = 1'b0;
  logic        bank_bit = 1'b0;
  logic        ram_sel;
  logic [12:0] ram_addr;
  logic        win_sel;
  logic [23:0] win_addr;
  logic [8:0]  bank_base;

  int errors = 0;
  int checks = 0;
  logic [8:0] exp_bank = '0;

  always #10 clk = ~clk;

  bank_window_decoder u_dut (
    .clk(clk), .rst(rst), .acc_strobe(acc_strobe), .acc_addr(acc_addr),
    .bank_wr(bank_wr), .bank_bit(bank_bit), .ram_sel(ram_sel),
    .ram_addr(ram_addr), .win_sel(win_sel), .win_addr(win_addr),
    .bank_base(bank_base)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bank_write(input logic b);
    @(negedge clk);
    bank_wr = 1'b1; bank_bit = b;
    @(negedge clk);
    bank_wr = 1'b0;
    exp_bank = {b, exp_bank[8:1]};
  endtask

  task automatic access(input logic [15:0] a);
    @(negedge clk);
    acc_strobe = 1'b1; acc_addr = a;
    @(negedge clk);
    acc_strobe = 1'b0;
  endtask

  task automatic expect_outputs(input string req, input logic rs, input logic [12:0] ra,
                                input logic ws, input logic [23:0] wa);
    check({req, " ram_sel"}, 32'(ram_sel), 32'(rs));
    check({req, " ram_addr"}, 32'(ram_addr), 32'(ra));
    check({req, " win_sel"}, 32'(win_sel), 32'(ws));
    check({req, " win_addr"}, 32'(win_addr), 32'(wa));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_bank = '0;
    check("R1 bank", 32'(bank_base), 32'h0);
    expect_outputs("R1", 1'b0, 13'h0, 1'b0, 24'h0);
  endtask

  task automatic t_ram();
    access(16'h0000); expect_outputs("R4 low", 1'b1, 13'h0000, 1'b0, 24'h0);
    access(16'h2000); expect_outputs("R4 mirror", 1'b1, 13'h0000, 1'b0, 24'h0);
    access(16'h3FFF); expect_outputs("R4 top", 1'b1, 13'h1FFF, 1'b0, 24'h0);
    access(16'h1ABC); expect_outputs("R4 mid", 1'b1, 13'h1ABC, 1'b0, 24'h0);
  endtask

  task automatic t_hole();
    access(16'h4000); expect_outputs("R6 low", 1'b0, 13'h0, 1'b0, 24'h0);
    access(16'h7FFF); expect_outputs("R6 top", 1'b0, 13'h0, 1'b0, 24'h0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    acc_addr = 16'h8123;
    @(negedge clk);
    expect_outputs("R7 idle", 1'b0, 13'h0, 1'b0, 24'h0);
  endtask

  task automatic t_window(input string tag);
    access(16'h8000);
    expect_outputs({tag, " R5 base"}, 1'b0, 13'h0, 1'b1, {exp_bank, 15'h0000});
    access(16'hFFFF);
    expect_outputs({tag, " R5 end"}, 1'b0, 13'h0, 1'b1, {exp_bank, 15'h7FFF});
  endtask

  task automatic t_shift();
    bank_write(1'b1);
    check("R2 first", 32'(bank_base), 32'h100);
    bank_write(1'b0);
    check("R2 second", 32'(bank_base), 32'h080);
    repeat (3) @(negedge clk);
    check("R3 hold", 32'(bank_base), 32'h080);
    t_window("R2");
  endtask

  task automatic t_nine(input logic [8:0] pat, input string tag);
    for (int i = 0; i < 9; i++) bank_write(pat[i]);
    check({tag, " R9 load"}, 32'(bank_base), 32'(pat));
    check({tag, " R9 model"}, 32'(bank_base), 32'(exp_bank));
    t_window(tag);
  endtask

  task automatic t_same_cycle();
    // Bank write and window access in one cycle: access sees old base (R8)
    logic [8:0] old;
    old = exp_bank;
    @(negedge clk);
    acc_strobe = 1'b1; acc_addr = 16'h9234;
    bank_wr = 1'b1; bank_bit = ~old[0];
    @(negedge clk);
    acc_strobe = 1'b0; bank_wr = 1'b0;
    exp_bank = {~old[0], old[8:1]};
    expect_outputs("R8 old base", 1'b0, 13'h0, 1'b1, {old, 15'h1234});
    check("R8 bank updated", 32'(bank_base), 32'(exp_bank));
    access(16'h9234);
    expect_outputs("R8 new base", 1'b0, 13'h0, 1'b1, {exp_bank, 15'h1234});
  endtask

  task automatic t_exclusive();
    logic [15:0] addrs [4] = '{16'h0010, 16'h5000, 16'hC000, 16'h3000};
    for (int i = 0; i < 4; i++) begin
      access(addrs[i]);
      check("R10 exclusive", 32'(ram_sel & win_sel), 32'h0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_window("R1 reset base");
    t_ram();
    t_hole();
    t_idle();
    t_shift();
    t_nine(9'b101010101, "alt");
    t_nine(9'b000000001, "first-bit");
    t_nine(9'b111111111, "ones");
    t_same_cycle();
    t_exclusive();
    t_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule